// File: doc/BRIEF.md
# Sparse Row-Compressed by Column-Compressed Matrix Multiplier

This block multiplies two 16×16 integer matrices that are both held in compressed form. The left operand A is stored row by row: a value array, an array of column numbers for those values, and a 17-entry offset table giving where each row begins. The right operand B is stored column by column: a value array, an array of row numbers, and a 17-entry offset table giving where each column begins. The product C is dense and lands in an internal 256-word result RAM.

A host fills the six arrays through one write port, pulses `start`, waits for `done`, and then reads C through a combinational read port at address `i*16+k`. The controller first zeroes the result RAM. It then walks the rows of A and the nonzeros in each row. For each of those nonzeros it walks the columns of B and their nonzeros. Whenever the inner indices agree, it accumulates one product. The loop bounds come from the offset tables, so the run time follows the number of stored nonzeros and not the matrix size.

Top module: `spmm_csr_csc`

## Requirements
- R1: After reset `busy` and `done` are both 0.
- R2: With `busy` low, a write (`wr_en`=1) stores `wr_data` into the array picked by `wr_sel`, at entry `wr_addr`. The encodings are: 0 = A values (32 bits), 1 = A column numbers (low 4 bits), 2 = A row offsets (entries 0..16, low 9 bits), 3 = B values (32 bits), 4 = B row numbers (low 4 bits), 5 = B column offsets (entries 0..16, low 9 bits). The nonzeros of A row i occupy entries ptrA[i] to ptrA[i+1]−1, and the nonzeros of B column k occupy entries ptrB[k] to ptrB[k+1]−1.
- R3: Every accepted start zeroes the whole result RAM before any accumulation, so nothing from a previous run survives.
- R4: When done, `rd_data` at `rd_addr`=i*16+k equals the sum, modulo 2^32, of valA[j]·valB[m] over every A entry j of row i and every B entry m of column k whose A column number equals the B row number.
- R5: A row or column with equal adjacent offsets adds nothing. A matrix with zero stored nonzeros yields an all-zero C.
- R6: Fully dense operands (offset tables ending at 256) give the complete dense product.
- R7: `busy` is high from the cycle after an accepted start until the run ends. `done` then rises, and it stays high until the next accepted start.
- R8: While `busy` is high, `start` pulses and array writes are ignored and do not alter the result of the run in progress.
- R9: Pairs whose inner indices differ never change C. Operands whose index sets are disjoint yield an all-zero C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Array write strobe |
| wr_sel | input | 3 | Array selector (see R2) |
| wr_addr | input | 8 | Array entry |
| wr_data | input | 32 | Write data |
| start | input | 1 | Begin a multiplication |
| rd_addr | input | 8 | Result address i*16+k |
| rd_data | output | 32 | Result word at `rd_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid |

## Verification
Host traffic and the computation can land in the same cycle. A write to an operand array or a fresh `start` can arrive while the walker is reading those arrays. The bench provokes this by starting a run and, tens of cycles into it, writing a new value to an A value entry and a B offset entry and pulsing `start` again. It judges the outcome by comparing the final C against the dense reference computed from the original operands, and by checking that `busy` was still high when the intrusion happened.

// File: rtl/spmm_csr_csc.sv
module spmm_csr_csc #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_sel,
  input  logic [$clog2(N*N)-1:0]     wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic                       start,
  input  logic [$clog2(N*N)-1:0]     rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic                       busy,
  output logic                       done
);
  localparam int NZ = N * N;
  localparam int AW = $clog2(NZ);
  localparam int PW = AW + 1;

  logic [DW-1:0] a_val [NZ];
  logic [DW-1:0] b_val [NZ];
  logic [DW-1:0] c_mem [NZ];
  logic [IW-1:0] a_col [NZ];
  logic [IW-1:0] b_row [NZ];
  logic [PW-1:0] a_ptr [N+1];
  logic [PW-1:0] b_ptr [N+1];

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ROW, S_AENT, S_BENT} st_t;
  st_t st;

  logic [IW:0]   ri;
  logic [IW-1:0] ck;
  logic [PW-1:0] aj, bm;
  logic [AW-1:0] clr;

  wire [IW:0]   ri_nx = ri + 1'b1;
  wire [IW:0]   ck_nx = {1'b0, ck} + 1'b1;
  wire          a_live = aj < a_ptr[ri_nx];
  wire          b_live = bm < b_ptr[ck_nx];
  wire          hit    = a_col[aj[AW-1:0]] == b_row[bm[AW-1:0]];
  wire [AW-1:0] cidx   = {ri[IW-1:0], ck};
  wire [DW-1:0] prod   = a_val[aj[AW-1:0]] * b_val[bm[AW-1:0]];
  wire          go     = (st == S_IDLE) && start;

  assign busy    = st != S_IDLE;
  assign rd_data = c_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en && !busy) begin
      case (wr_sel)
        3'd0: a_val[wr_addr] <= wr_data;
        3'd1: a_col[wr_addr] <= wr_data[IW-1:0];
        3'd2: if (wr_addr <= AW'(N)) a_ptr[wr_addr[IW:0]] <= wr_data[PW-1:0];
        3'd3: b_val[wr_addr] <= wr_data;
        3'd4: b_row[wr_addr] <= wr_data[IW-1:0];
        3'd5: if (wr_addr <= AW'(N)) b_ptr[wr_addr[IW:0]] <= wr_data[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CLR) c_mem[clr] <= '0;
    else if (st == S_BENT && b_live && hit) c_mem[cidx] <= c_mem[cidx] + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      done <= 1'b0;
      ri   <= '0;
      ck   <= '0;
      aj   <= '0;
      bm   <= '0;
      clr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_CLR;
          clr  <= '0;
          done <= 1'b0;
        end
        S_CLR: begin
          clr <= clr + 1'b1;
          if (clr == AW'(NZ - 1)) begin
            st <= S_ROW;
            ri <= '0;
          end
        end
        S_ROW: begin
          if (ri == (IW+1)'(N)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            aj <= a_ptr[ri];
            st <= S_AENT;
          end
        end
        S_AENT: begin
          if (!a_live) begin
            ri <= ri_nx;
            st <= S_ROW;
          end else begin
            ck <= '0;
            bm <= b_ptr[0];
            st <= S_BENT;
          end
        end
        S_BENT: begin
          if (!b_live) begin
            if (ck == IW'(N - 1)) begin
              aj <= aj + 1'b1;
              st <= S_AENT;
            end else begin
              ck <= ck_nx[IW-1:0];
              bm <= b_ptr[ck_nx];
            end
          end else begin
            bm <= bm + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLR) |=> (c_mem[$past(clr)] == '0)); // R3
  AST_NO_STRAY_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BENT && !(b_live && hit)) |=> (c_mem[$past(cidx)] == $past(c_mem[cidx]))); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && !done)); // R7
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AENT) |-> (ri < (IW+1)'(N))); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BENT && start) |=> (st != S_CLR)); // R8
endmodule

// File: tb/spmm_csr_csc_tb_top.sv
module spmm_csr_csc_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic busy, done;
  int total = 0, bad = 0, cyc = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] ad [256];
  logic [31:0] bd [256];
  logic [31:0] refc [256];

  always #2 clk = ~clk;

  spmm_csr_csc dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int addr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_addr = 8'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic gen(int pa, int pb, bit disjoint);
    for (int x = 0; x < 256; x++) begin
      ad[x] = ((rnd() % 100) < 32'(pa)) ? rnd() : 0;
      bd[x] = ((rnd() % 100) < 32'(pb)) ? rnd() : 0;
      if (ad[x] == 0 && pa == 100) ad[x] = 1;
      if (bd[x] == 0 && pb == 100) bd[x] = 1;
      if (disjoint) begin
        if ((x % 16) % 2 == 1) ad[x] = 0;
        if ((x / 16) % 2 == 0) bd[x] = 0;
      end
    end
  endtask

  task automatic load();
    int n;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      wr(2, i, n);
      for (int c = 0; c < 16; c++) if (ad[i*16+c] != 0) begin
        wr(0, n, ad[i*16+c]); wr(1, n, c); n++;
      end
    end
    wr(2, 16, n);
    n = 0;
    for (int k = 0; k < 16; k++) begin
      wr(5, k, n);
      for (int r = 0; r < 16; r++) if (bd[r*16+k] != 0) begin
        wr(3, n, bd[r*16+k]); wr(4, n, r); n++;
      end
    end
    wr(5, 16, n);
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 16; k++) begin
        logic [31:0] s;
        s = 0;
        for (int m = 0; m < 16; m++) s = s + ad[i*16+m] * bd[m*16+k];
        refc[i*16+k] = s;
      end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(string req);
    int w;
    w = 0;
    while (!done && w < 100000) begin @(negedge clk); w++; end
    chk(req, 32'(done), 1);
  endtask

  task automatic compare(string req);
    int miss, first;
    logic [31:0] fa;
    miss = 0; first = -1; fa = 0;
    for (int x = 0; x < 256; x++) begin
      @(negedge clk); rd_addr = 8'(x); #1;
      if (rd_data !== refc[x]) begin
        if (first < 0) begin first = x; fa = rd_data; end
        miss++;
      end
    end
    total = total + 1;
    if (miss != 0) begin
      bad = bad + 1;
      $display("FAIL %s: entry %0d actual=%0h expected=%0h (%0d mismatches)",
               req, first, fa, refc[first], miss);
    end
  endtask

  task automatic run(string req);
    pulse_start();
    #1 chk("R7 busy after start", 32'(busy), 1);
    chk("R7 done cleared", 32'(done), 0);
    wait_done(req);
    compare(req);
  endtask

  task automatic t_reset();
    #1 chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
  endtask

  task automatic t_sparse();
    gen(30, 30, 0); load(); run("R4 R2 30pct");
    gen(10, 15, 0); load(); run("R4 10pct");
  endtask

  task automatic t_dense();
    gen(100, 100, 0); load(); run("R6 dense");
  endtask

  task automatic t_empty();
    gen(40, 40, 0);
    for (int c = 0; c < 16; c++) begin ad[3*16+c] = 0; ad[9*16+c] = 0; bd[c*16+5] = 0; end
    load(); run("R5 empty rows/cols");
    for (int x = 0; x < 256; x++) begin ad[x] = 0; bd[x] = 0; end
    load(); run("R5 zero nonzeros R3");
  endtask

  task automatic t_disjoint();
    gen(50, 50, 0); load(); run("R4 pre");
    gen(60, 60, 1); load(); run("R9 disjoint R3");
  endtask

  task automatic t_busy();
    gen(30, 30, 0); load();
    pulse_start();
    repeat (60) @(negedge clk);
    #1 chk("R8 still busy", 32'(busy), 1);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'd0; wr_addr = 8'd0; wr_data = 32'hDEAD_BEEF; start = 1;
    @(negedge clk);
    wr_sel = 3'd5; wr_addr = 8'd8; wr_data = 32'd0; start = 0;
    @(negedge clk);
    wr_en = 0;
    wait_done("R7 done after intrusion");
    compare("R8 intrusion ignored");
    #1 chk("R7 done holds", 32'(done), 1);
    run("R8 arrays intact rerun");
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sparse();
    t_empty();
    t_disjoint();
    t_busy();
    t_dense();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule